// File: doc/BRIEF.md
# Machine-Cycle Sequencer and Power-Mode Controller

This block runs from the oscillator clock and produces the core timing of an 8-bit control processor. A machine cycle is split into a fixed number of states (six by default). Each state takes two oscillator periods: a first-phase period followed by a second-phase period. The current state number and phase flags drive the CPU's micro-sequencing. A one-period strobe marks the last phase of every machine cycle.

The block also runs the two software-entered low-power modes. Idle gates only the CPU clock enable: the peripheral enable and the phase sequencer keep running. Stop gates both enables and drops the oscillator-run signal, which parks the sequencer at state 1, phase 1. Either external interrupt or the real-time-clock interrupt ends either mode, after a synchronizer. A hardware reset also ends either mode. On the way out of stop, the CPU enable is held off for a settling window before execution resumes at the start of a machine cycle.

Top module: `mcyc_pwr_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), the block is in run mode with state_num = 1, ph1 = 1, ph2 = 0, cpu_clk_en = per_clk_en = osc_run = 1, and idle_bit, stop_bit and cyc_stb all 0.
- R2: Outside stop and settling, each clock moves the sequencer forward one phase. ph1 and ph2 alternate, starting with ph1. state_num goes 1, 2, ... 6 and wraps to 1, so a machine cycle lasts 12 clocks.
- R3: cyc_stb is 1 for exactly the one clock in which state_num = 6 and ph2 = 1, and only while cpu_clk_en = 1. It stays 0 for the whole of idle, stop and settling.
- R4: A req_idle pulse in run mode enters idle at the next clock. cpu_clk_en goes to 0 and idle_bit to 1, while per_clk_en and osc_run stay 1 and the sequencer keeps counting.
- R5: A req_stop pulse in run mode enters stop at the next clock. cpu_clk_en, per_clk_en and osc_run go to 0, stop_bit goes to 1, and the sequencer shows state 1, phase 1 for as long as stop lasts.
- R6: When req_idle and req_stop are high in the same run-mode clock, stop is entered rather than idle.
- R7: In idle, a high level on ext_int0, ext_int1 or rtc_int returns the block to run mode. This happens at the third clock edge after the input rises: two synchronizer stages plus the mode register. At that edge cpu_clk_en becomes 1 and idle_bit 0, and the sequencer goes on without a restart.
- R8: In stop, the same wake inputs, with the same three-edge latency, enter a settling window. There osc_run and per_clk_en are 1, stop_bit is 0, cpu_clk_en is 0 and the sequencer holds at state 1, phase 1 for 16 clocks. On the next clock cpu_clk_en becomes 1 at state 1, phase 1, and the first cyc_stb follows 11 clocks later.
- R9: Mode requests are ignored outside run mode. req_stop during idle leaves per_clk_en at 1. req_idle during stop leaves the stop outputs unchanged.
- R10: Asserting rst_n during stop returns the outputs to the R1 values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| req_idle | input | 1 | Software request to enter idle, one-clock pulse |
| req_stop | input | 1 | Software request to enter stop, one-clock pulse |
| ext_int0 | input | 1 | External interrupt 0, level, asynchronous |
| ext_int1 | input | 1 | External interrupt 1, level, asynchronous |
| rtc_int | input | 1 | Real-time-clock interrupt, level, asynchronous |
| state_num | output | 3 | Current state of the machine cycle, 1 to 6 |
| ph1 | output | 1 | First-phase half of the state |
| ph2 | output | 1 | Second-phase half of the state |
| cyc_stb | output | 1 | End-of-machine-cycle strobe |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator keep-running request |
| idle_bit | output | 1 | Idle mode flag |
| stop_bit | output | 1 | Stop mode flag |

## Verification
A corrupted phase or state register shows up at the ports within one clock. Either ph1 and ph2 fail to alternate, or state_num leaves the 1-to-6 ring, and this also moves cyc_stb off its 12-clock spacing. A wrong mode register shows on the three enables and the two mode flags in the clock after it goes wrong. A settling counter that is off by any amount makes cpu_clk_en rise early or late, which shows directly in the clock at which execution resumes after stop. A sequencer that is not parked shows as a state other than 1, phase 1 at that point.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      PM_RUN    = 2'd0,
      PM_IDLE   = 2'd1,
      PM_STOP   = 2'd2,
      PM_SETTLE = 2'd3
   } pm_mode_e;

   function automatic int clog2_min1(input int value);
      int w;
      w = 1;
      while ((1 << w) < value) w++;
      return w;
   endfunction

endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
   parameter int NUM_SRC = 3,
   parameter int STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] async_in,
   output logic [NUM_SRC-1:0] sync_out
);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("pmc_wake_sync: NUM_SRC must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("pmc_wake_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_passthru
      assign sync_out = async_in;
   end else begin : g_chain
      logic [NUM_SRC-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
         end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
         end
      end

      assign sync_out = stage_q[STAGES-1];
   end

endmodule

// File: rtl/pmc_phase_seq.sv
module pmc_phase_seq #(
   parameter int NUM_STATES = 6,
   parameter int SW         = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_clr,
   output logic [SW-1:0] state_q,
   output logic          phase_q
);

   localparam logic [SW-1:0] FIRST_ST = SW'(1);
   localparam logic [SW-1:0] LAST_ST  = SW'(NUM_STATES);

   if (NUM_STATES < 2) begin : g_bad_states
      $error("pmc_phase_seq: NUM_STATES must be at least 2");
   end
   if ((1 << SW) <= NUM_STATES) begin : g_bad_width
      $error("pmc_phase_seq: SW too narrow for NUM_STATES");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FIRST_ST;
         phase_q <= 1'b0;
      end else if (hold_clr) begin
         state_q <= FIRST_ST;
         phase_q <= 1'b0;
      end else if (!phase_q) begin
         phase_q <= 1'b1;
      end else begin
         phase_q <= 1'b0;
         state_q <= (state_q == LAST_ST) ? FIRST_ST : state_q + FIRST_ST;
      end
   end

   a_r2_phase_alternates : assert property (@(posedge clk) disable iff (!rst_n)
      !hold_clr |=> (phase_q != $past(phase_q)));

   a_r2_state_wraps : assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_clr && phase_q && state_q == LAST_ST) |=> (state_q == FIRST_ST && !phase_q));

   a_r2_state_steps : assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_clr && phase_q && state_q != LAST_ST) |=> (state_q == $past(state_q) + FIRST_ST));

   a_r2_state_in_ring : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q >= FIRST_ST) && (state_q <= LAST_ST));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
#(
   parameter int SETTLE_CYCLES = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_idle,
   input  logic     req_stop,
   input  logic     wake,
   output pm_mode_e mode_q,
   output pm_mode_e mode_nxt
);

   localparam int CW = clog2_min1(SETTLE_CYCLES);
   localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYCLES - 1);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("pmc_mode_fsm: SETTLE_CYCLES must be at least 1");
   end

   logic [CW-1:0] settle_cnt_q;
   logic [CW-1:0] settle_cnt_nxt;

   always_comb begin
      mode_nxt       = mode_q;
      settle_cnt_nxt = settle_cnt_q;
      unique case (mode_q)
         PM_RUN: begin
            if (req_stop)      mode_nxt = PM_STOP;   // stop wins when both set
            else if (req_idle) mode_nxt = PM_IDLE;
         end
         PM_IDLE: begin
            if (wake) mode_nxt = PM_RUN;
         end
         PM_STOP: begin
            if (wake) begin
               mode_nxt       = PM_SETTLE;
               settle_cnt_nxt = '0;
            end
         end
         PM_SETTLE: begin
            if (settle_cnt_q == CNT_LAST) mode_nxt = PM_RUN;
            else settle_cnt_nxt = settle_cnt_q + CW'(1);
         end
         default: mode_nxt = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q       <= PM_RUN;
         settle_cnt_q <= '0;
      end else begin
         mode_q       <= mode_nxt;
         settle_cnt_q <= settle_cnt_nxt;
      end
   end

   a_r6_stop_priority : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_RUN && req_stop) |=> (mode_q == PM_STOP));

   a_r4_idle_entry : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_RUN && req_idle && !req_stop) |=> (mode_q == PM_IDLE));

   a_r7_idle_exit : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_IDLE && wake) |=> (mode_q == PM_RUN));

   a_r9_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_IDLE && !wake) |=> (mode_q == PM_IDLE));

   a_r9_stop_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_STOP && !wake) |=> (mode_q == PM_STOP));

   a_r8_settle_window : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_SETTLE && settle_cnt_q != CNT_LAST) |=> (mode_q == PM_SETTLE));

   a_r8_settle_ends : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_SETTLE && settle_cnt_q == CNT_LAST) |=> (mode_q == PM_RUN));

endmodule

// File: rtl/mcyc_pwr_ctrl.sv
module mcyc_pwr_ctrl
   import pmc_pkg::*;
#(
   parameter  int NUM_STATES    = 6,
   parameter  int SETTLE_CYCLES = 16,
   parameter  int SYNC_STAGES   = 2,
   localparam int SW            = clog2_min1(NUM_STATES + 1)
) (
   input  logic          osc_clk,
   input  logic          rst_n,
   input  logic          req_idle,
   input  logic          req_stop,
   input  logic          ext_int0,
   input  logic          ext_int1,
   input  logic          rtc_int,
   output logic [SW-1:0] state_num,
   output logic          ph1,
   output logic          ph2,
   output logic          cyc_stb,
   output logic          cpu_clk_en,
   output logic          per_clk_en,
   output logic          osc_run,
   output logic          idle_bit,
   output logic          stop_bit
);

   localparam int NUM_WAKE = 3;
   localparam logic [SW-1:0] LAST_ST = SW'(NUM_STATES);

   logic [NUM_WAKE-1:0] wake_raw;
   logic [NUM_WAKE-1:0] wake_sync;
   logic                wake_any;
   pm_mode_e            mode_q;
   pm_mode_e            mode_nxt;
   logic                seq_hold;
   logic                phase_q;

   assign wake_raw = {rtc_int, ext_int1, ext_int0};
   assign wake_any = |wake_sync;

   pmc_wake_sync #(
      .NUM_SRC (NUM_WAKE),
      .STAGES  (SYNC_STAGES)
   ) u_sync (
      .clk      (osc_clk),
      .rst_n    (rst_n),
      .async_in (wake_raw),
      .sync_out (wake_sync)
   );

   pmc_mode_fsm #(
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) u_fsm (
      .clk      (osc_clk),
      .rst_n    (rst_n),
      .req_idle (req_idle),
      .req_stop (req_stop),
      .wake     (wake_any),
      .mode_q   (mode_q),
      .mode_nxt (mode_nxt)
   );

   // Park the sequencer from the stop-entry edge up to and including the
   // edge that leaves settling, so execution resumes at state 1, phase 1.
   assign seq_hold = (mode_nxt == PM_STOP) || (mode_nxt == PM_SETTLE) ||
                     (mode_q == PM_SETTLE);

   pmc_phase_seq #(
      .NUM_STATES (NUM_STATES),
      .SW         (SW)
   ) u_seq (
      .clk      (osc_clk),
      .rst_n    (rst_n),
      .hold_clr (seq_hold),
      .state_q  (state_num),
      .phase_q  (phase_q)
   );

   assign ph1        = !phase_q;
   assign ph2        = phase_q;
   assign cpu_clk_en = (mode_q == PM_RUN);
   assign per_clk_en = (mode_q != PM_STOP);
   assign osc_run    = (mode_q != PM_STOP);
   assign idle_bit   = (mode_q == PM_IDLE);
   assign stop_bit   = (mode_q == PM_STOP);
   assign cyc_stb    = cpu_clk_en && phase_q && (state_num == LAST_ST);

   a_r3_strobe_single : assert property (@(posedge osc_clk) disable iff (!rst_n)
      cyc_stb |=> !cyc_stb);

   a_r8_resume_at_start : assert property (@(posedge osc_clk) disable iff (!rst_n)
      ($rose(cpu_clk_en) && $past(mode_q == PM_SETTLE)) |-> (state_num == SW'(1) && ph1));

   a_r5_stop_frozen : assert property (@(posedge osc_clk) disable iff (!rst_n)
      (stop_bit && $past(stop_bit)) |-> ($stable(state_num) && $stable(ph1)));

   a_r4_idle_keeps_periph : assert property (@(posedge osc_clk) disable iff (!rst_n)
      idle_bit |-> (per_clk_en && osc_run && !cpu_clk_en));

endmodule

// File: tb/tb_mcyc_pwr_ctrl.sv
module tb_mcyc_pwr_ctrl;

   typedef struct {
      int          due;
      string       tag;
      logic [12:0] v;
   } item_t;

   logic       osc_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       req_idle = 1'b0;
   logic       req_stop = 1'b0;
   logic       ext_int0 = 1'b0;
   logic       ext_int1 = 1'b0;
   logic       rtc_int  = 1'b0;
   logic [2:0] state_num;
   logic       ph1, ph2, cyc_stb, cpu_clk_en, per_clk_en, osc_run, idle_bit, stop_bit;

   int    checks = 0;
   int    errors = 0;
   int    cyc    = 0;
   int    base   = 0;
   bit    done   = 1'b0;
   item_t sb_q[$];

   mcyc_pwr_ctrl dut (
      .osc_clk    (osc_clk),
      .rst_n      (rst_n),
      .req_idle   (req_idle),
      .req_stop   (req_stop),
      .ext_int0   (ext_int0),
      .ext_int1   (ext_int1),
      .rtc_int    (rtc_int),
      .state_num  (state_num),
      .ph1        (ph1),
      .ph2        (ph2),
      .cyc_stb    (cyc_stb),
      .cpu_clk_en (cpu_clk_en),
      .per_clk_en (per_clk_en),
      .osc_run    (osc_run),
      .idle_bit   (idle_bit),
      .stop_bit   (stop_bit)
   );

   always #4 osc_clk = ~osc_clk;

   always @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   function automatic logic [12:0] actual();
      return {cpu_clk_en, per_clk_en, osc_run, idle_bit, stop_bit, cyc_stb,
              state_num, ph1, ph2};
   endfunction

   // pos: 0..11 within the machine cycle; strobe expected only if stb_ok
   function automatic logic [12:0] expv(bit cpu, bit per, bit osc, bit idl, bit stp,
                                        int pos, bit stb_ok);
      logic [2:0] st;
      bit         p2;
      st = 3'(pos / 2 + 1);
      p2 = (pos % 2) == 1;
      return {cpu, per, osc, idl, stp, (stb_ok && pos == 11), st, !p2, p2};
   endfunction

   function automatic int pos_of(int due);
      return (due - base) % 12;
   endfunction

   task automatic compare(string tag, logic [12:0] exp_v);
      logic [12:0] act_v;
      act_v = actual();
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, act_v, exp_v);
      end
   endtask

   // monitor: pops and compares expected items when their cycle comes up
   always @(negedge osc_clk) begin
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         item_t it;
         it = sb_q.pop_front();
         if (it.due < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s stale item due=%0d actual=none expected=%b", it.tag, it.due, it.v);
         end else begin
            compare(it.tag, it.v);
         end
      end
   end

   task automatic at_neg();
      @(negedge osc_clk);
      #1;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) at_neg();
   endtask

   task automatic push(int due, string tag, logic [12:0] v);
      item_t it;
      it.due = due;
      it.tag = tag;
      it.v   = v;
      sb_q.push_back(it);
   endtask

   task automatic run_from(int first, int last, string tag);
      for (int k = first; k <= last; k++) push(k, tag, expv(1, 1, 1, 0, 0, pos_of(k), 1));
   endtask

   task automatic idle_from(int first, int last, string tag);
      for (int k = first; k <= last; k++) push(k, tag, expv(0, 1, 1, 1, 0, pos_of(k), 0));
   endtask

   task automatic stop_from(int first, int last, string tag);
      for (int k = first; k <= last; k++) push(k, tag, expv(0, 0, 0, 0, 1, 0, 0));
   endtask

   task automatic settle_from(int first, int last, string tag);
      for (int k = first; k <= last; k++) push(k, tag, expv(0, 1, 1, 0, 0, 0, 0));
   endtask

   // idle entry, then exit through the given wake source (0: int0, 2: rtc)
   task automatic idle_cycle(int src, string tag);
      int c, d;
      c = cyc;
      idle_from(c + 1, c + 4, "R4");
      req_idle = 1'b1;
      at_neg();
      req_idle = 1'b0;
      wait_cyc(3);
      d = cyc;
      idle_from(d + 1, d + 2, tag);
      run_from(d + 3, d + 14, tag);
      if (src == 0) ext_int0 = 1'b1; else rtc_int = 1'b1;
      wait_cyc(3);
      ext_int0 = 1'b0;
      rtc_int  = 1'b0;
      wait_cyc(12);
   endtask

   initial begin
      int c, d;
      #20;
      compare("R1 reset", expv(1, 1, 1, 0, 0, 0, 0));
      @(negedge osc_clk);
      rst_n = 1'b1;
      #1;
      base = 0;

      // R2 R3: free-running sequence over two machine cycles
      for (int k = 1; k <= 24; k++) push(k, "R2 R3", expv(1, 1, 1, 0, 0, k % 12, 1));
      wait_cyc(26);

      // R4 entry, R9 stop request ignored in idle, R3 strobe gated, R7 exit
      c = cyc;
      idle_from(c + 1, c + 4, "R4");
      req_idle = 1'b1;
      at_neg();
      req_idle = 1'b0;
      wait_cyc(3);
      idle_from(c + 5, c + 16, "R9 R3");
      req_stop = 1'b1;
      at_neg();
      req_stop = 1'b0;
      wait_cyc(11);
      d = cyc;
      idle_from(d + 1, d + 2, "R7 int0");
      run_from(d + 3, d + 14, "R7 int0");
      ext_int0 = 1'b1;
      wait_cyc(3);
      ext_int0 = 1'b0;
      wait_cyc(12);

      // R7 again, waking from the RTC source
      idle_cycle(2, "R7 rtc");

      // R5 stop entry, R9 idle request ignored during stop
      c = cyc;
      stop_from(c + 1, c + 3, "R5");
      req_stop = 1'b1;
      at_neg();
      req_stop = 1'b0;
      wait_cyc(2);
      stop_from(c + 4, c + 7, "R9");
      req_idle = 1'b1;
      at_neg();
      req_idle = 1'b0;
      wait_cyc(4);

      // R8 wake with ext_int1: settle 16 clocks, resume at S1 ph1
      d = cyc;
      stop_from(d + 1, d + 2, "R8");
      settle_from(d + 3, d + 18, "R8 R3");
      base = d + 19;
      run_from(d + 19, d + 31, "R8 R3");
      ext_int1 = 1'b1;
      wait_cyc(3);
      ext_int1 = 1'b0;
      wait_cyc(30);

      // R6 both requests at once, then wake from the RTC source
      c = cyc;
      stop_from(c + 1, c + 3, "R6");
      req_idle = 1'b1;
      req_stop = 1'b1;
      at_neg();
      req_idle = 1'b0;
      req_stop = 1'b0;
      wait_cyc(3);
      d = cyc;
      stop_from(d + 1, d + 2, "R8 rtc");
      settle_from(d + 3, d + 18, "R8 rtc");
      base = d + 19;
      run_from(d + 19, d + 20, "R8 rtc");
      rtc_int = 1'b1;
      wait_cyc(3);
      rtc_int = 1'b0;
      wait_cyc(19);

      // R10: asynchronous reset during stop
      c = cyc;
      stop_from(c + 1, c + 2, "R10 pre");
      req_stop = 1'b1;
      at_neg();
      req_stop = 1'b0;
      wait_cyc(2);
      rst_n = 1'b0;
      #1;
      compare("R10 async reset", expv(1, 1, 1, 0, 0, 0, 0));
      @(negedge osc_clk);
      rst_n = 1'b1;
      wait_cyc(2);

      if (sb_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R2 scoreboard actual=%0d pending expected=0", sb_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule